// File: doc/BRIEF.md
# Cluster Debug Halt Coordinator

This block spreads debug halts across a small cluster of cores and freezes a shared timestamp counter while chosen cores are stopped. It holds three configuration values. The participation mask has one bit per core and marks the cores that join cross-core halting. The cause enable is a 4-bit filter that picks which halt causes count. The counter-halt mask has one bit per core and marks the cores whose halt stops the shared counter.

Software writes a command word and a data word in the same cycle. The command word carries an opcode and a parameter. A read command copies the chosen value into the readback register. A core that is a member of the participation mask and shows an enabled cause becomes a halt source. Every other member then gets a registered halt request. The request holds for as long as some other member is still a source. The 64-bit free-running counter advances by one on every clock, except while a core in the counter-halt mask reports any halt cause.

Top module: `halt_coord`

## Requirements
- R1: During and right after reset, the participation mask, the cause enable, the counter-halt mask, `haltReq`, `readBack` and `counterValue` are all zero, and `ctrFreeze` is low while no cause input is set.
- R2: When `cmdValid` is high and opcode `cmdWord[7:0]` is 0x11, the participation mask takes `cmdData[NUM_CORES-1:0]`. Opcode 0x10 loads `readBack` with that mask, zero-extended, at the same edge.
- R3: Opcode 0x12 loads the cause enable from `cmdWord[11:8]` and the participation mask from `cmdData[NUM_CORES-1:0]`. Opcode 0x13 loads `readBack[3:0]` with the cause enable and the upper bits with zero.
- R4: Opcode 0x21 loads the counter-halt mask from `cmdData[NUM_CORES-1:0]`. Opcode 0x20 loads `readBack` with that mask. Neither opcode changes the participation mask.
- R5: Core c reports its causes on `haltCause[4c+3:4c]`, with bit 0 the status halt flag, bit 1 an actionpoint, bit 2 a breakpoint and bit 3 a self-halt. Core c is a halt source only when it is a participant and at least one of its cause bits is set with the matching cause-enable bit set.
- R6: `haltReq[k]` goes high at the first clock edge at which participant k sees a halt source among the other participants. It goes low at the first edge at which no such source remains.
- R7: A core outside the participation mask never receives a request and never causes one. A source that is the only source does not request itself.
- R8: `counterValue` grows by one at every clock edge at which `ctrFreeze` is low, and holds its value at every edge at which `ctrFreeze` is high.
- R9: `ctrFreeze` is high, without any clock delay, exactly when some core in the counter-halt mask has any cause bit set. The cause enable does not affect it.
- R10: Any opcode other than the six above, and any command word presented while `cmdValid` is low, leaves every mask and `readBack` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one command per cycle |
| cmdWord | input | 16 | Opcode in [7:0], parameter in [15:8] |
| cmdData | input | DATA_W | Write value for set commands |
| haltCause | input | 4*NUM_CORES | Per-core halt cause bits |
| haltReq | output | NUM_CORES | Registered halt request per core |
| ctrFreeze | output | 1 | Shared counter freeze enable |
| counterValue | output | CTR_W | Shared free-running counter |
| readBack | output | DATA_W | Value returned by the last read command |

## Verification
The bench builds the block with four cores, a 32-bit data word and a 64-bit counter. At that size every task can be swept in full. Each of the 16 participation masks is paired with each of the 16 source patterns. Each of the 16 cause enables is paired with each single cause bit. Each of the 16 counter-halt masks is paired with each of the 16 halted-core patterns. The expected requests, freeze levels and counter steps come from plain mask arithmetic in the bench.

// File: rtl/halt_coord_pkg.sv
package halt_coord_pkg;
  localparam int CAUSE_W = 4;

  localparam logic [7:0] OP_RD_SEL   = 8'h10;
  localparam logic [7:0] OP_WR_SEL   = 8'h11;
  localparam logic [7:0] OP_WR_CAUSE = 8'h12;
  localparam logic [7:0] OP_RD_CAUSE = 8'h13;
  localparam logic [7:0] OP_RD_CTR   = 8'h20;
  localparam logic [7:0] OP_WR_CTR   = 8'h21;

  typedef struct packed {
    logic wrSel;
    logic wrCause;
    logic wrCtr;
    logic rdSel;
    logic rdCause;
    logic rdCtr;
  } strobe_t;
endpackage

// File: rtl/halt_coord_ctrl.sv
module halt_coord_ctrl
  import halt_coord_pkg::*;
(
  input  logic       cmdValid,
  input  logic [7:0] opcode,
  output strobe_t    strobes
);
  always_comb begin
    strobes = '0;
    if (cmdValid) begin
      unique case (opcode)
        OP_WR_SEL:   strobes.wrSel   = 1'b1;
        OP_WR_CAUSE: strobes.wrCause = 1'b1;
        OP_WR_CTR:   strobes.wrCtr   = 1'b1;
        OP_RD_SEL:   strobes.rdSel   = 1'b1;
        OP_RD_CAUSE: strobes.rdCause = 1'b1;
        OP_RD_CTR:   strobes.rdCtr   = 1'b1;
        default:     strobes = '0;
      endcase
    end
  end
endmodule

// File: rtl/halt_coord_dp.sv
module halt_coord_dp
  import halt_coord_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int CTR_W     = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strobes,
  input  logic [7:0]                   param,
  input  logic [DATA_W-1:0]            cmdData,
  input  logic [CAUSE_W*NUM_CORES-1:0] haltCause,
  output logic [NUM_CORES-1:0]         haltReq,
  output logic                         ctrFreeze,
  output logic [CTR_W-1:0]             counterValue,
  output logic [DATA_W-1:0]            readBack
);
  logic [NUM_CORES-1:0] selMask;
  logic [NUM_CORES-1:0] ctrMask;
  logic [CAUSE_W-1:0]   causeEn;
  logic [NUM_CORES-1:0] srcVec;
  logic [NUM_CORES-1:0] rawHalted;
  logic [NUM_CORES-1:0] reqNext;

  // configuration registers and readback
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selMask  <= '0;
      ctrMask  <= '0;
      causeEn  <= '0;
      readBack <= '0;
    end else begin
      if (strobes.wrSel || strobes.wrCause) selMask <= cmdData[NUM_CORES-1:0];
      if (strobes.wrCause) causeEn <= param[CAUSE_W-1:0];
      if (strobes.wrCtr)   ctrMask <= cmdData[NUM_CORES-1:0];
      if (strobes.rdSel)        readBack <= DATA_W'(selMask);
      else if (strobes.rdCause) readBack <= DATA_W'(causeEn);
      else if (strobes.rdCtr)   readBack <= DATA_W'(ctrMask);
    end
  end

  // per-core source detection and request fan-out
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [CAUSE_W-1:0] myCause;
    assign myCause      = haltCause[CAUSE_W*c +: CAUSE_W];
    assign rawHalted[c] = |myCause;
    assign srcVec[c]    = selMask[c] & |(myCause & causeEn);
    assign reqNext[c]   = selMask[c] & |(srcVec & ~(NUM_CORES'(1) << c));
  end

  always_ff @(posedge clk) begin
    if (!rstN) haltReq <= '0;
    else       haltReq <= reqNext;
  end

  // shared timestamp counter
  assign ctrFreeze = |(rawHalted & ctrMask);

  always_ff @(posedge clk) begin
    if (!rstN)          counterValue <= '0;
    else if (!ctrFreeze) counterValue <= counterValue + CTR_W'(1);
  end
endmodule

// File: rtl/halt_coord.sv
module halt_coord
  import halt_coord_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int CTR_W     = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cmdValid,
  input  logic [15:0]                  cmdWord,
  input  logic [DATA_W-1:0]            cmdData,
  input  logic [CAUSE_W*NUM_CORES-1:0] haltCause,
  output logic [NUM_CORES-1:0]         haltReq,
  output logic                         ctrFreeze,
  output logic [CTR_W-1:0]             counterValue,
  output logic [DATA_W-1:0]            readBack
);
  strobe_t strobes;

  halt_coord_ctrl u_ctrl (
    .cmdValid (cmdValid),
    .opcode   (cmdWord[7:0]),
    .strobes  (strobes)
  );

  halt_coord_dp #(
    .NUM_CORES (NUM_CORES),
    .DATA_W    (DATA_W),
    .CTR_W     (CTR_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .param        (cmdWord[15:8]),
    .cmdData      (cmdData),
    .haltCause    (haltCause),
    .haltReq      (haltReq),
    .ctrFreeze    (ctrFreeze),
    .counterValue (counterValue),
    .readBack     (readBack)
  );
endmodule

// File: rtl/halt_coord_chk.sv
module halt_coord_chk #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int CTR_W     = 64
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   cmdValid,
  input logic [4*NUM_CORES-1:0] haltCause,
  input logic [NUM_CORES-1:0]   haltReq,
  input logic                   ctrFreeze,
  input logic [CTR_W-1:0]       counterValue,
  input logic [DATA_W-1:0]      readBack
);
  p_ctr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrFreeze |=> counterValue == $past(counterValue));

  p_ctr_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrFreeze |=> counterValue == $past(counterValue) + CTR_W'(1));

  p_freeze_needs_halt_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrFreeze |-> haltCause != '0);

  p_no_source_no_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    haltCause == '0 |=> haltReq == '0);

  p_readback_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> $stable(readBack));

  p_lone_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    $countones(haltCause) <= 1 |=> $countones(haltReq) <= NUM_CORES - 1);
endmodule

bind halt_coord halt_coord_chk #(
  .NUM_CORES (NUM_CORES),
  .DATA_W    (DATA_W),
  .CTR_W     (CTR_W)
) u_chk (.*);

// File: tb/sim_halt_coord.sv
module sim_halt_coord;
  localparam int N  = 4;
  localparam int DW = 32;
  localparam int CW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [15:0]   cmdWord = '0;
  logic [DW-1:0] cmdData = '0;
  logic [4*N-1:0] haltCause = '0;
  logic [N-1:0]  haltReq;
  logic          ctrFreeze;
  logic [CW-1:0] counterValue;
  logic [DW-1:0] readBack;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  halt_coord #(.NUM_CORES(N), .DATA_W(DW), .CTR_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .cmdData(cmdData), .haltCause(haltCause), .haltReq(haltReq),
    .ctrFreeze(ctrFreeze), .counterValue(counterValue), .readBack(readBack)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doCmd(logic [7:0] op, logic [7:0] prm, logic [DW-1:0] d);
    cmdValid = 1'b1;
    cmdWord  = {prm, op};
    cmdData  = d;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdWord  = '0;
    cmdData  = '0;
  endtask

  task automatic finish();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    logic [N-1:0] expReq;
    logic [CW-1:0] v0;
    logic fz;

    repeat (3) @(negedge clk);
    chk("R1 haltReq", 64'(haltReq), 0);
    chk("R1 readBack", 64'(readBack), 0);
    chk("R1 counter", counterValue, 0);
    chk("R1 ctrFreeze", 64'(ctrFreeze), 0);
    rstN = 1'b1;
    doCmd(8'h10, 0, 0); chk("R1 sel mask", 64'(readBack), 0);
    doCmd(8'h13, 0, 0); chk("R1 cause enable", 64'(readBack), 0);
    doCmd(8'h20, 0, 0); chk("R1 ctr mask", 64'(readBack), 0);

    // R2 participation mask
    for (int m = 0; m < 16; m++) begin
      doCmd(8'h11, 0, DW'(m) | 32'hFFFF_FFF0);
      doCmd(8'h10, 0, 0);
      chk("R2 sel readback", 64'(readBack), 64'(m));
    end

    // R3 cause enable with mask
    for (int e = 0; e < 16; e++) begin
      doCmd(8'h12, 8'(e), DW'(15 - e));
      doCmd(8'h13, 0, 0);
      chk("R3 cause readback", 64'(readBack), 64'(e));
      doCmd(8'h10, 0, 0);
      chk("R3 sel from cause cmd", 64'(readBack), 64'(15 - e));
    end

    // R4 counter-halt mask
    doCmd(8'h11, 0, 32'h5);
    for (int m = 0; m < 16; m++) begin
      doCmd(8'h21, 0, DW'(m));
      doCmd(8'h20, 0, 0);
      chk("R4 ctr readback", 64'(readBack), 64'(m));
    end
    doCmd(8'h10, 0, 0);
    chk("R4 sel untouched", 64'(readBack), 64'h5);

    // R10 unknown opcode and idle strobe
    doCmd(8'h7F, 8'h0F, 32'hF);
    chk("R10 readback after bad opcode", 64'(readBack), 64'h5);
    cmdWord = {8'h0F, 8'h11}; cmdData = 32'hA;
    @(negedge clk);
    cmdWord = '0; cmdData = '0;
    chk("R10 readback with cmdValid low", 64'(readBack), 64'h5);
    doCmd(8'h10, 0, 0);
    chk("R10 sel unchanged", 64'(readBack), 64'h5);
    doCmd(8'h20, 0, 0);
    chk("R10 ctr unchanged", 64'(readBack), 64'hF);
    doCmd(8'h21, 0, 0);

    // R6 and R7: every participation mask against every source pattern
    for (int m = 0; m < 16; m++) begin
      doCmd(8'h12, 8'hF, DW'(m));
      for (int p = 0; p < 16; p++) begin
        for (int j = 0; j < N; j++)
          haltCause[4*j +: 4] = p[j] ? 4'(1 << ((j + p) % 4)) : 4'h0;
        for (int k = 0; k < N; k++)
          expReq[k] = m[k] && ((p & m & ~(1 << k)) != 0);
        @(negedge clk);
        chk("R6 R7 haltReq", 64'(haltReq), 64'(expReq));
        haltCause = '0;
        @(negedge clk);
        chk("R6 release", 64'(haltReq), 0);
      end
    end

    // R5 cause filtering, core 0 as the only source
    for (int e = 0; e < 16; e++) begin
      doCmd(8'h12, 8'(e), 32'hF);
      for (int b = 0; b < 4; b++) begin
        haltCause = 16'(1 << b);
        @(negedge clk);
        chk("R5 cause filter", 64'(haltReq), e[b] ? 64'hE : 64'h0);
        haltCause = '0;
        @(negedge clk);
      end
    end

    // R8 and R9: counter freeze with the cause enable cleared
    doCmd(8'h12, 8'h0, 32'hF);
    for (int cm = 0; cm < 16; cm++) begin
      doCmd(8'h21, 0, DW'(cm));
      for (int p = 0; p < 16; p++) begin
        for (int j = 0; j < N; j++)
          haltCause[4*j +: 4] = p[j] ? 4'(1 << (j % 4)) : 4'h0;
        #1;
        fz = (cm & p) != 0;
        chk("R9 ctrFreeze", 64'(ctrFreeze), 64'(fz));
        v0 = counterValue;
        @(negedge clk);
        chk("R8 counter step", counterValue, fz ? v0 : v0 + 1);
        chk("R9 no request when cause enable is zero", 64'(haltReq), 0);
      end
      haltCause = '0;
      @(negedge clk);
    end

    finish();
  end
endmodule